// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block keeps the sharer record for one memory block in a directory-based coherence scheme. Instead of one presence bit per node, it stores a few node pointers, each `log2(NODES)` bits wide. When a new sharer arrives and every pointer is already in use, the entry falls back to an overflow representation. A parameter picks that representation at build time. The broadcast policy sets a single flag that covers every node. The replacement policy evicts one stored pointer in round-robin order and invalidates the evicted node. The coarse policy rewrites the entry as a vector with one bit per group of `GROUP` nodes.

The block accepts three commands: add a sharer, write by a node, and clear. A write walks the entry and emits the nodes to invalidate, one node ID per pulse. Under the broadcast policy it instead emits one invalidate-all indication that names the writer as the excluded node. When the walk ends, the entry holds only the writer, in pointer form. While a walk is in progress, the block does not accept commands.

Top module: `ptrdir_entry`

## Requirements
- R1: A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_op` 2'b01 adds `cmd_node` as a sharer in the lowest free pointer slot. Adding a node that is already recorded changes nothing. `cmd_op` 2'b00 does nothing.
- R2: In pointer form, a write (`cmd_op` 2'b10) emits each recorded sharer other than the writer exactly once, on `inv_valid` with the ID on `inv_node`. The slots are walked in order, one slot per cycle.
- R3: With POLICY 0, an add into a full entry sets a broadcast flag. A later write then gives one cycle with `inv_all` high and `inv_valid` low, and `inv_node` equal to the writer, which is the node exempt from the broadcast.
- R4: With POLICY 1, an add into a full entry overwrites the slot at a victim index that starts at 0 and steps round-robin modulo PTRS. The displaced node appears on `inv_valid`/`inv_node` in the cycle after the add is accepted.
- R5: With POLICY 2, an add into a full entry converts the entry to a group vector. Node n belongs to group n/GROUP. Later adds set their group bit. A write invalidates every node, in ascending order, of each group whose bit is set, except the writer.
- R6: Each write ends with exactly one `inv_done` pulse. After the pulse, the entry holds only the writer in pointer form, with the broadcast flag and coarse form cleared and the victim index reset to 0.
- R7: `cmd_op` 2'b11 empties the entry and emits no invalidation.
- R8: `cmd_ready` is low from the cycle after a write is accepted until the walk ends. Commands presented during that time are ignored.
- R9: After reset the entry is empty, `cmd_ready` is high and no invalidation output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 01 add, 10 write, 11 clear, 00 none |
| cmd_node | input | log2(NODES) | Requesting node |
| cmd_ready | output | 1 | Entry can take a command |
| inv_valid | output | 1 | `inv_node` names a node to invalidate |
| inv_node | output | log2(NODES) | Node to invalidate, or the exempt writer when `inv_all` is high |
| inv_all | output | 1 | Invalidate all nodes except `inv_node` |
| inv_done | output | 1 | Last cycle of a write walk |

## Verification
A wrong internal state stays hidden until the next write or replacement, because the stored sharers are only visible through the invalidation stream. The bench therefore ends each command sequence with a write. It compares the whole set of invalidated nodes, the number of pulses, the broadcast flag and the done pulse against values computed independently, within at most NODES+2 cycles of the write. A missed replacement victim, a wrong group bit or a stale overflow flag shows up as an extra or missing node in that set. A victim index that fails to wrap shows up at the very next overflow add.

// File: rtl/ptrdir_entry.sv
module ptrdir_entry #(
  parameter int NODES  = 16,
  parameter int PTRS   = 4,
  parameter int GROUP  = 4,
  parameter int POLICY = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [$clog2(NODES)-1:0] cmd_node,
  output logic                     cmd_ready,
  output logic                     inv_valid,
  output logic [$clog2(NODES)-1:0] inv_node,
  output logic                     inv_all,
  output logic                     inv_done
);
  localparam int IDW  = $clog2(NODES);
  localparam int GRPS = NODES / GROUP;
  localparam int GW   = (GRPS > 1) ? $clog2(GRPS) : 1;
  localparam int PW   = (PTRS > 1) ? $clog2(PTRS) : 1;
  localparam int SCW  = IDW + 1;

  localparam logic [1:0] OP_ADD = 2'b01;
  localparam logic [1:0] OP_WR  = 2'b10;
  localparam logic [1:0] OP_CLR = 2'b11;

  logic [IDW-1:0]  ptr [PTRS];
  logic [PTRS-1:0] vld;
  logic            ovf, crs, busy;
  logic [GRPS-1:0] cvec;
  logic [PW-1:0]   vic;
  logic [SCW-1:0]  scan;
  logic [IDW-1:0]  wr_node;

  function automatic logic [GW-1:0] grp(input logic [IDW-1:0] n);
    logic [IDW-1:0] q;
    q = n / IDW'(GROUP);
    return q[GW-1:0];
  endfunction

  assign cmd_ready = !busy;

  logic accept;
  assign accept = cmd_valid && !busy;

  logic            hit, free_any;
  logic [PW-1:0]   free_idx;
  logic [GRPS-1:0] conv;
  always_comb begin
    hit = 1'b0;
    free_any = 1'b0;
    free_idx = '0;
    conv = '0;
    for (int i = PTRS - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_any = 1'b1;
        free_idx = PW'(i);
      end
    end
    for (int i = 0; i < PTRS; i++) begin
      if (vld[i] && ptr[i] == cmd_node) hit = 1'b1;
      if (vld[i]) conv[grp(ptr[i])] = 1'b1;
    end
    conv[grp(cmd_node)] = 1'b1;
  end

  logic [IDW-1:0] sn;
  logic           s_hit, s_last;
  always_comb begin
    if (crs) begin
      sn    = scan[IDW-1:0];
      s_hit = cvec[grp(sn)] && (sn != wr_node);
    end else begin
      sn    = ptr[scan[PW-1:0]];
      s_hit = vld[scan[PW-1:0]] && (sn != wr_node);
    end
    if (ovf)      s_last = 1'b1;
    else if (crs) s_last = (scan == SCW'(NODES - 1));
    else          s_last = (scan == SCW'(PTRS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PTRS; i++) ptr[i] <= '0;
      vld       <= '0;
      ovf       <= 1'b0;
      crs       <= 1'b0;
      cvec      <= '0;
      vic       <= '0;
      busy      <= 1'b0;
      scan      <= '0;
      wr_node   <= '0;
      inv_valid <= 1'b0;
      inv_node  <= '0;
      inv_all   <= 1'b0;
      inv_done  <= 1'b0;
    end else begin
      inv_valid <= 1'b0;
      inv_all   <= 1'b0;
      inv_done  <= 1'b0;
      if (busy) begin
        if (ovf) begin
          inv_all  <= 1'b1;
          inv_node <= wr_node;
        end else if (s_hit) begin
          inv_valid <= 1'b1;
          inv_node  <= sn;
        end
        if (s_last) begin
          busy     <= 1'b0;
          inv_done <= 1'b1;
          scan     <= '0;
          vld      <= PTRS'(1);
          ptr[0]   <= wr_node;
          ovf      <= 1'b0;
          crs      <= 1'b0;
          cvec     <= '0;
          vic      <= '0;
        end else begin
          scan <= scan + SCW'(1);
        end
      end else if (accept) begin
        case (cmd_op)
          OP_ADD: begin
            if (crs) begin
              cvec[grp(cmd_node)] <= 1'b1;
            end else if (ovf || hit) begin
              vld <= vld;
            end else if (free_any) begin
              vld[free_idx] <= 1'b1;
              ptr[free_idx] <= cmd_node;
            end else if (POLICY == 0) begin
              ovf <= 1'b1;
            end else if (POLICY == 1) begin
              ptr[vic]  <= cmd_node;
              inv_valid <= 1'b1;
              inv_node  <= ptr[vic];
              vic       <= (vic == PW'(PTRS - 1)) ? '0 : vic + PW'(1);
            end else begin
              crs  <= 1'b1;
              cvec <= conv;
              vld  <= '0;
            end
          end
          OP_WR: begin
            busy    <= 1'b1;
            scan    <= '0;
            wr_node <= cmd_node;
          end
          OP_CLR: begin
            vld  <= '0;
            ovf  <= 1'b0;
            crs  <= 1'b0;
            cvec <= '0;
            vic  <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < PTRS; i++)
      for (int j = i + 1; j < PTRS; j++)
        if (vld[i] && vld[j] && ptr[i] == ptr[j]) dup = 1'b1;
  end

  // R1
  no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);

  // R2
  no_self_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && $past(busy)) |-> (inv_node != wr_node));

  // R3
  bcast_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> (inv_done && !inv_valid));

  // R6
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> cmd_ready);

  // R8
  busy_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_WR) |=> !cmd_ready);
endmodule

// File: tb/sim_ptrdir_entry.sv
`timescale 1ns/1ps
module sim_ptrdir_entry;
  localparam int NODES = 16;
  localparam int PTRS  = 4;
  localparam int GROUP = 4;
  localparam int NROW  = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cv = 1'b0;
  logic [1:0] cop = 2'b00;
  logic [3:0] cnd = 4'd0;

  logic       rdy [3];
  logic       iv  [3];
  logic [3:0] inn [3];
  logic       ia  [3];
  logic       idn [3];

  always #4 clk = ~clk;

  ptrdir_entry #(.NODES(NODES), .PTRS(PTRS), .GROUP(GROUP), .POLICY(0)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv), .cmd_op(cop), .cmd_node(cnd),
    .cmd_ready(rdy[0]), .inv_valid(iv[0]), .inv_node(inn[0]), .inv_all(ia[0]), .inv_done(idn[0]));
  ptrdir_entry #(.NODES(NODES), .PTRS(PTRS), .GROUP(GROUP), .POLICY(1)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv), .cmd_op(cop), .cmd_node(cnd),
    .cmd_ready(rdy[1]), .inv_valid(iv[1]), .inv_node(inn[1]), .inv_all(ia[1]), .inv_done(idn[1]));
  ptrdir_entry #(.NODES(NODES), .PTRS(PTRS), .GROUP(GROUP), .POLICY(2)) u2 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv), .cmd_op(cop), .cmd_node(cnd),
    .cmd_ready(rdy[2]), .inv_valid(iv[2]), .inv_node(inn[2]), .inv_all(ia[2]), .inv_done(idn[2]));

  int errors = 0;
  int checks = 0;

  logic [15:0] msk [3];
  int          cnt [3];
  int          dn  [3];
  logic        allf;
  logic [3:0]  excl;

  task automatic clr_acc();
    for (int d = 0; d < 3; d++) begin
      msk[d] = '0; cnt[d] = 0; dn[d] = 0;
    end
    allf = 1'b0;
    excl = '0;
  endtask

  always @(negedge clk) begin
    for (int d = 0; d < 3; d++) begin
      if (iv[d]) begin
        msk[d][inn[d]] = 1'b1;
        cnt[d] = cnt[d] + 1;
      end
      if (idn[d]) dn[d] = dn[d] + 1;
    end
    if (ia[0]) begin
      allf = 1'b1;
      excl = inn[0];
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [3:0] nd);
    @(negedge clk);
    cv = 1'b1; cop = op; cnd = nd;
    @(negedge clk);
    cv = 1'b0; cop = 2'b00;
    repeat (NODES + 4) @(negedge clk);
    #1;
  endtask

  localparam logic [1:0] AD = 2'b01, WR = 2'b10, CL = 2'b11;

  // {op, node, mask u0, inv_all u0, mask u1, mask u2}
  localparam logic [54:0] VEC [NROW] = '{
    {CL, 4'd0,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd1,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd2,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd1,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd5,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd9,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd6,  16'h0000, 1'b0, 16'h0002, 16'h0000},
    {AD, 4'd10, 16'h0000, 1'b0, 16'h0004, 16'h0000},
    {AD, 4'd5,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {WR, 4'd5,  16'h0000, 1'b1, 16'h0640, 16'h0FDF},
    {AD, 4'd15, 16'h0000, 1'b0, 16'h0000, 16'h0000},
    {WR, 4'd15, 16'h0020, 1'b0, 16'h0020, 16'h0020},
    {WR, 4'd15, 16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd0,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {CL, 4'd0,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {WR, 4'd7,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd1,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd2,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd3,  16'h0000, 1'b0, 16'h0000, 16'h0000},
    {AD, 4'd4,  16'h0000, 1'b0, 16'h0080, 16'h0000},
    {AD, 4'd8,  16'h0000, 1'b0, 16'h0002, 16'h0000},
    {AD, 4'd12, 16'h0000, 1'b0, 16'h0004, 16'h0000},
    {AD, 4'd13, 16'h0000, 1'b0, 16'h0008, 16'h0000},
    {AD, 4'd14, 16'h0000, 1'b0, 16'h0010, 16'h0000},
    {WR, 4'd8,  16'h0000, 1'b1, 16'h7000, 16'hFEFF}
  };

  localparam string TAG [NROW] = '{
    "R7", "R1", "R1", "R1", "R1", "R1", "R3 R4 R5", "R4 R5", "R1",
    "R2 R3 R4 R5", "R1", "R6", "R6", "R1", "R7", "R7", "R1", "R1", "R1",
    "R4 R5", "R4 R5", "R4", "R4", "R4", "R3 R4 R5"
  };

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clr_acc();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    for (int d = 0; d < 3; d++) begin
      chk(rdy[d] == 1'b1, "R9", "ready after reset", int'(rdy[d]), 1);
      chk(!iv[d] && !ia[d] && !idn[d], "R9", "outputs idle after reset",
          int'({iv[d], ia[d], idn[d]}), 0);
    end
    clr_acc();
    issue(WR, 4'd3);
    for (int d = 0; d < 3; d++)
      chk(msk[d] == 16'h0 && cnt[d] == 0, "R9", "write on empty entry", int'(msk[d]), 0);
    chk(!allf, "R9", "no broadcast after reset", int'(allf), 0);
    clr_acc();

    for (int r = 0; r < NROW; r++) begin
      logic [54:0] v;
      logic [15:0] em [3];
      v = VEC[r];
      em[0] = v[32:17];
      em[1] = v[31-15:16-15] ^ 16'h0;
      em[1] = v[31:16] & 16'h0;
      em[1] = v[31:16];
      em[0] = v[48:33];
      em[2] = v[15:0];
      issue(v[54:53], v[52:49]);
      for (int d = 0; d < 3; d++) begin
        chk(msk[d] == em[d], TAG[r], $sformatf("row %0d u%0d invalidated set", r, d),
            int'(msk[d]), int'(em[d]));
        chk(cnt[d] == $countones(em[d]), TAG[r], $sformatf("row %0d u%0d pulse count", r, d),
            cnt[d], $countones(em[d]));
        chk(dn[d] == ((v[54:53] == WR) ? 1 : 0), "R6", $sformatf("row %0d u%0d done pulses", r, d),
            dn[d], (v[54:53] == WR) ? 1 : 0);
      end
      chk(allf == v[32], TAG[r], $sformatf("row %0d u0 broadcast", r), int'(allf), int'(v[32]));
      if (v[32])
        chk(excl == v[52:49], "R3", $sformatf("row %0d u0 exempt writer", r), int'(excl), int'(v[52:49]));
      clr_acc();
    end

    // R8: commands ignored while a write walk is running
    issue(CL, 4'd0);
    issue(AD, 4'd1);
    issue(AD, 4'd2);
    issue(AD, 4'd3);
    issue(AD, 4'd4);
    issue(AD, 4'd5);
    clr_acc();
    @(negedge clk);
    cv = 1'b1; cop = WR; cnd = 4'd9;
    @(negedge clk);
    for (int d = 0; d < 3; d++)
      chk(rdy[d] == 1'b0, "R8", $sformatf("u%0d ready low during walk", d), int'(rdy[d]), 0);
    cop = AD; cnd = 4'd15;
    @(negedge clk);
    cv = 1'b0; cop = 2'b00;
    repeat (NODES + 4) @(negedge clk);
    #1;
    clr_acc();
    issue(WR, 4'd4);
    for (int d = 0; d < 3; d++)
      chk(msk[d] == 16'h0200 && cnt[d] == 1, "R8", $sformatf("u%0d add during walk ignored", d),
          int'(msk[d]), 16'h0200);
    chk(!allf, "R6", "broadcast flag cleared by write", int'(allf), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule